// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This block is a watchdog peripheral on a simple 32-bit memory-mapped bus. Its registers are split into two frames selected by a frame input: a control frame, which holds the enable, the timeout offset and a 64-bit deadline, and a refresh frame, which holds a single refresh register. The refresh register can be mapped at a different privilege level from the control registers.

The block does not count down. Each restart stores an absolute deadline: the current value of an external free-running 64-bit system counter plus a 32-bit offset. The deadline is compared against the counter every cycle.

When the counter first reaches the deadline, the block raises a warning interrupt and moves the deadline one offset further on. If that second window also runs out with no refresh, the block raises a reset request. A refresh, a control write or an offset write clears both stages and starts a new window. Both frames also carry read-only identification words.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, the watchdog is disabled, both stage outputs are low, and the status word (control frame, offset 0x000), the offset (0x008) and both deadline words (0x010 low, 0x014 high) read zero.
- R2: A write to control offset 0x000 sets the enable from data bit 0. The status word reads enable in bit 0, the warning stage in bit 1 and the reset-request stage in bit 2, with all other bits zero.
- R3: A write to control offset 0x000, a write to control offset 0x008 (which also stores the new 32-bit offset) and any write to refresh offset 0x000 each restart the window. The deadline becomes the system counter at that clock edge plus the zero-extended offset in force after the write. The deadline reads back as two 32-bit words.
- R4: A write to control offset 0x010 or 0x014 replaces that half of the deadline and leaves both stage outputs unchanged.
- R5: While enabled with the warning low, the warning output rises on the clock edge after the counter is greater than or equal to the deadline, and not while the counter is below it. At that edge the deadline reloads to the counter plus the offset.
- R6: While the warning is high and the counter reaches the reloaded deadline, the reset request rises on the next edge. It never rises without the warning and stays high until a restart.
- R7: Every restart clears both the warning and the reset request on the same edge.
- R8: While disabled, no timeout is detected and both stage outputs stay low, whatever the counter value.
- R9: In both frames, offset 0xFCC reads an identification word: bits [19:16] architecture version 0, bits [15:12] revision, bits [11:8] and [6:0] the upper 4 and lower 7 bits of the 11-bit implementer code, and zeros elsewhere. Offset 0xFE8 reads the peripheral ID2 word. With the default parameters these are 0x0000383B and 0x0000001B.
- R10: Writes to reserved offsets, including refresh-frame offsets other than 0x000 and the identification words, change no state and trigger no restart. Reads from reserved offsets, and from refresh offset 0x000, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_cnt_i | input | 64 | Free-running system counter value |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_frame_i | input | 1 | 0 selects the control frame, 1 the refresh frame |
| bus_addr_i | input | 12 | Byte offset within the frame |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational during a read access |
| warn_irq_o | output | 1 | First-stage timeout interrupt |
| reset_req_o | output | 1 | Second-stage reset request |

## Verification
The bench builds the block with its default parameters: a 64-bit counter split into two 32-bit deadline words, revision 3, implementer code 0x43B and ID2 word 0x1B. Because the bench drives the system counter directly instead of letting it run, it can set counter values above 2^32 and land exactly one count below and exactly on a deadline. This makes the zero-extension of the offset, the high deadline word and the exact compare boundary each visible in a single cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_OFFSET  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CMP     = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_REFRESH = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_IDENT   = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_PID2    = 12'hFE8;

  localparam logic [3:0] ARCH_VER = 4'h0;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_OFFSET,
    RD_CMP,
    RD_IDENT,
    RD_PID2
  } rd_sel_e;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int unsigned CMP_WORDS = 2,
  localparam int unsigned IDX_W = (CMP_WORDS > 1) ? $clog2(CMP_WORDS) : 1
) (
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic                 frame_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 ctrl_we_o,
  output logic                 offset_we_o,
  output logic                 refresh_we_o,
  output logic [CMP_WORDS-1:0] cmp_we_o,
  output rd_sel_e              rd_sel_o,
  output logic [IDX_W-1:0]     rd_word_o
);
  logic                 hit_status, hit_offset, hit_refresh, hit_ident, hit_pid2;
  logic [CMP_WORDS-1:0] hit_cmp;
  logic                 wr, rd;

  assign wr = valid_i & write_i;
  assign rd = valid_i & ~write_i;

  assign hit_status  = !frame_i && (addr_i == OFS_STATUS);
  assign hit_offset  = !frame_i && (addr_i == OFS_OFFSET);
  assign hit_refresh =  frame_i && (addr_i == OFS_REFRESH);
  assign hit_ident   = (addr_i == OFS_IDENT);
  assign hit_pid2    = (addr_i == OFS_PID2);

  for (genvar g = 0; g < CMP_WORDS; g++) begin : g_cmp_hit
    assign hit_cmp[g] = !frame_i && (addr_i == OFS_CMP + ADDR_W'(4 * g));
    assign cmp_we_o[g] = wr & hit_cmp[g];
  end

  assign ctrl_we_o    = wr & hit_status;
  assign offset_we_o  = wr & hit_offset;
  assign refresh_we_o = wr & hit_refresh;

  always_comb begin
    rd_sel_o  = RD_NONE;
    rd_word_o = '0;
    if (rd) begin
      if (hit_status)     rd_sel_o = RD_STATUS;
      else if (hit_offset) rd_sel_o = RD_OFFSET;
      else if (hit_ident)  rd_sel_o = RD_IDENT;
      else if (hit_pid2)   rd_sel_o = RD_PID2;
      for (int i = 0; i < CMP_WORDS; i++) begin
        if (hit_cmp[i]) begin
          rd_sel_o  = RD_CMP;
          rd_word_o = IDX_W'(i);
        end
      end
    end
  end

  // R10: at most one register takes a write per access
  always_comb begin
    a_r10_one_strobe: assert ($onehot0({ctrl_we_o, offset_we_o, refresh_we_o, cmp_we_o}));
  end
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              offset_we_i,
  input  logic              refresh_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [DATA_W-1:0] offset_o,
  output logic              restart_o,
  output logic [DATA_W-1:0] restart_off_o
);
  logic              en_q;
  logic [DATA_W-1:0] offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      offset_q <= '0;
    end else begin
      if (ctrl_we_i)   en_q     <= wdata_i[0];
      if (offset_we_i) offset_q <= wdata_i;
    end
  end

  assign restart_o     = ctrl_we_i | offset_we_i | refresh_we_i;
  // a new offset takes effect for the window it restarts
  assign restart_off_o = offset_we_i ? wdata_i : offset_q;
  assign en_o          = en_q;
  assign offset_o      = offset_q;

  a_r2_enable_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (en_q == $past(wdata_i[0])));
  a_r3_offset_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_we_i |=> (offset_q == $past(wdata_i)));
endmodule

// File: rtl/wdt_deadline.sv
module wdt_deadline
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned CMP_WORDS = CNT_W / DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 en_i,
  input  logic                 restart_i,
  input  logic [DATA_W-1:0]    restart_off_i,
  input  logic [DATA_W-1:0]    offset_i,
  input  logic [CMP_WORDS-1:0] cmp_we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]     cmp_o,
  output logic                 ws0_o,
  output logic                 ws1_o
);
  logic [CNT_W-1:0] cmp_q, restart_val, reload_val;
  logic             ws0_q, ws1_q, due;

  assign restart_val = cnt_i + CNT_W'(restart_off_i);
  assign reload_val  = cnt_i + CNT_W'(offset_i);
  assign due         = en_i && (cnt_i >= cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else if (restart_i) begin
      cmp_q <= restart_val;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else if (|cmp_we_i) begin
      for (int i = 0; i < CMP_WORDS; i++) begin
        if (cmp_we_i[i]) cmp_q[i*DATA_W +: DATA_W] <= wdata_i;
      end
    end else if (due) begin
      if (!ws0_q) begin
        ws0_q <= 1'b1;
        cmp_q <= reload_val;
      end else begin
        ws1_q <= 1'b1;
      end
    end
  end

  assign cmp_o = cmp_q;
  assign ws0_o = ws0_q;
  assign ws1_o = ws1_q;

  a_r5_reload_on_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws0_q) |-> (cmp_q == $past(reload_val)));
  a_r6_reset_needs_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ws1_q |-> ws0_q);
  a_r6_reset_after_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws1_q) |-> $past(ws0_q));
  a_r7_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!ws0_q && !ws1_q));
  a_r4_cmp_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmp_we_i) |=> (ws0_q == $past(ws0_q) && ws1_q == $past(ws1_q)));
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!ws0_q && !ws1_q));
endmodule

// File: rtl/wdt_read_mux.sv
module wdt_read_mux
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 64,
  parameter logic [3:0]  REVISION  = 4'h3,
  parameter logic [10:0] IMPL_CODE = 11'h43B,
  parameter logic [31:0] PART_ID2  = 32'h0000_001B,
  localparam int unsigned CMP_WORDS = CNT_W / DATA_W,
  localparam int unsigned IDX_W = (CMP_WORDS > 1) ? $clog2(CMP_WORDS) : 1
) (
  input  rd_sel_e           rd_sel_i,
  input  logic [IDX_W-1:0]  rd_word_i,
  input  logic              en_i,
  input  logic              ws0_i,
  input  logic              ws1_i,
  input  logic [DATA_W-1:0] offset_i,
  input  logic [CNT_W-1:0]  cmp_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] IDENT_WORD =
    {12'h000, ARCH_VER, REVISION, IMPL_CODE[10:7], 1'b0, IMPL_CODE[6:0]};

  always_comb begin
    unique case (rd_sel_i)
      RD_STATUS: rdata_o = {{(DATA_W-3){1'b0}}, ws1_i, ws0_i, en_i};
      RD_OFFSET: rdata_o = offset_i;
      RD_CMP:    rdata_o = cmp_i[int'(rd_word_i)*DATA_W +: DATA_W];
      RD_IDENT:  rdata_o = IDENT_WORD;
      RD_PID2:   rdata_o = PART_ID2;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 64,
  parameter logic [3:0]  REVISION  = 4'h3,
  parameter logic [10:0] IMPL_CODE = 11'h43B,
  parameter logic [31:0] PART_ID2  = 32'h0000_001B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  sys_cnt_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              bus_frame_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              warn_irq_o,
  output logic              reset_req_o
);
  localparam int unsigned CMP_WORDS = CNT_W / DATA_W;
  localparam int unsigned IDX_W = (CMP_WORDS > 1) ? $clog2(CMP_WORDS) : 1;

  logic                 ctrl_we, offset_we, refresh_we, restart, en;
  logic [CMP_WORDS-1:0] cmp_we;
  rd_sel_e              rd_sel;
  logic [IDX_W-1:0]     rd_word;
  logic [DATA_W-1:0]    offset, restart_off;
  logic [CNT_W-1:0]     cmp;
  logic                 ws0, ws1;

  wdt_decode #(.CMP_WORDS(CMP_WORDS)) u_decode (
    .valid_i     (bus_valid_i),
    .write_i     (bus_write_i),
    .frame_i     (bus_frame_i),
    .addr_i      (bus_addr_i),
    .ctrl_we_o   (ctrl_we),
    .offset_we_o (offset_we),
    .refresh_we_o(refresh_we),
    .cmp_we_o    (cmp_we),
    .rd_sel_o    (rd_sel),
    .rd_word_o   (rd_word)
  );

  wdt_ctrl_regs u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .offset_we_i  (offset_we),
    .refresh_we_i (refresh_we),
    .wdata_i      (bus_wdata_i),
    .en_o         (en),
    .offset_o     (offset),
    .restart_o    (restart),
    .restart_off_o(restart_off)
  );

  wdt_deadline #(.CNT_W(CNT_W)) u_deadline (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_i        (sys_cnt_i),
    .en_i         (en),
    .restart_i    (restart),
    .restart_off_i(restart_off),
    .offset_i     (offset),
    .cmp_we_i     (cmp_we),
    .wdata_i      (bus_wdata_i),
    .cmp_o        (cmp),
    .ws0_o        (ws0),
    .ws1_o        (ws1)
  );

  wdt_read_mux #(
    .CNT_W    (CNT_W),
    .REVISION (REVISION),
    .IMPL_CODE(IMPL_CODE),
    .PART_ID2 (PART_ID2)
  ) u_rmux (
    .rd_sel_i (rd_sel),
    .rd_word_i(rd_word),
    .en_i     (en),
    .ws0_i    (ws0),
    .ws1_i    (ws1),
    .offset_i (offset),
    .cmp_i    (cmp),
    .rdata_o  (bus_rdata_o)
  );

  assign warn_irq_o  = ws0;
  assign reset_req_o = ws1;

  // R10: idle bus returns zero
  a_r10_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |-> (bus_rdata_o == '0));
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        valid = 1'b0, write = 1'b0, frame = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        warn, rreq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wdt_two_stage dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_cnt_i(cnt),
    .bus_valid_i(valid), .bus_write_i(write), .bus_frame_i(frame),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .warn_irq_o(warn), .reset_req_o(rreq)
  );

  typedef struct packed {
    logic        wr;
    logic        frm;
    logic [11:0] adr;
    logic [31:0] dat;
    logic [63:0] c;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 12'h008, 32'h0000_0050, 64'h100,         32'h0,         8'd3},  // R3 offset write restarts
    '{1'b0, 1'b0, 12'h010, 32'h0,         64'h100,         32'h0000_0150, 8'd3},
    '{1'b0, 1'b0, 12'h014, 32'h0,         64'h100,         32'h0,         8'd3},
    '{1'b0, 1'b0, 12'h008, 32'h0,         64'h100,         32'h0000_0050, 8'd3},
    '{1'b1, 1'b1, 12'h000, 32'h0,         64'h1000,        32'h0,         8'd3},  // R3 refresh restarts
    '{1'b0, 1'b0, 12'h010, 32'h0,         64'h1000,        32'h0000_1050, 8'd3},
    '{1'b1, 1'b1, 12'h004, 32'h1,         64'h2000,        32'h0,         8'd10}, // R10 reserved refresh offset
    '{1'b0, 1'b0, 12'h010, 32'h0,         64'h2000,        32'h0000_1050, 8'd10},
    '{1'b1, 1'b0, 12'h004, 32'hFFFF,      64'h2000,        32'h0,         8'd10},
    '{1'b0, 1'b0, 12'h000, 32'h0,         64'h2000,        32'h0,         8'd10},
    '{1'b0, 1'b0, 12'h004, 32'h0,         64'h2000,        32'h0,         8'd10},
    '{1'b0, 1'b1, 12'h000, 32'h0,         64'h2000,        32'h0,         8'd10},
    '{1'b1, 1'b0, 12'h008, 32'hFFFF_FFFF, 64'h1_2345_0000, 32'h0,         8'd3},  // R3 zero-extension
    '{1'b0, 1'b0, 12'h010, 32'h0,         64'h1_2345_0000, 32'h2344_FFFF, 8'd3},
    '{1'b0, 1'b0, 12'h014, 32'h0,         64'h1_2345_0000, 32'h0000_0002, 8'd3},
    '{1'b1, 1'b0, 12'h010, 32'hAAAA_5555, 64'h10,          32'h0,         8'd4},  // R4 direct deadline write
    '{1'b0, 1'b0, 12'h010, 32'h0,         64'h10,          32'hAAAA_5555, 8'd4},
    '{1'b1, 1'b0, 12'h014, 32'h0000_0007, 64'h10,          32'h0,         8'd4},
    '{1'b0, 1'b0, 12'h014, 32'h0,         64'h10,          32'h0000_0007, 8'd4},
    '{1'b1, 1'b0, 12'hFCC, 32'h1234_5678, 64'h10,          32'h0,         8'd10}  // R10 ident is read-only
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic f, input logic [11:0] a, input logic [31:0] d);
    valid = 1'b1; write = 1'b1; frame = f; addr = a; wdata = d;
    tick();
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(input logic f, input logic [11:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; frame = f; addr = a;
    #1 d = rdata;
    valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 warn", warn, 0);
    check("R1 rreq", rreq, 0);
    bus_rd(0, 12'h000, d); check("R1 status", d, 0);
    bus_rd(0, 12'h008, d); check("R1 offset", d, 0);
    bus_rd(0, 12'h010, d); check("R1 cmp lo", d, 0);
    bus_rd(0, 12'h014, d); check("R1 cmp hi", d, 0);

    // R9 identification: rev 3, impl 0x43B -> 0x0000383B
    bus_rd(0, 12'hFCC, d); check("R9 ident ctrl", d, 32'h0000_383B);
    bus_rd(1, 12'hFCC, d); check("R9 ident refresh", d, 32'h0000_383B);
    bus_rd(0, 12'hFE8, d); check("R9 pid2 ctrl", d, 32'h1B);
    bus_rd(1, 12'hFE8, d); check("R9 pid2 refresh", d, 32'h1B);

    // table walk (watchdog disabled throughout)
    for (int i = 0; i < NV; i++) begin
      cnt = VECS[i].c;
      if (VECS[i].wr) begin
        bus_wr(VECS[i].frm, VECS[i].adr, VECS[i].dat);
      end else begin
        bus_rd(VECS[i].frm, VECS[i].adr, d);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), d, VECS[i].exp);
      end
    end
    bus_rd(0, 12'hFCC, d); check("R10 ident unchanged", d, 32'h0000_383B);

    // R2 enable set and clear
    cnt = 64'h10;
    bus_wr(0, 12'h000, 32'h1);
    bus_rd(0, 12'h000, d); check("R2 enabled", d, 32'h1);
    bus_wr(0, 12'h000, 32'h0);
    bus_rd(0, 12'h000, d); check("R2 disabled", d, 32'h0);

    // R5 first stage, exact boundary
    cnt = 64'h100;
    bus_wr(0, 12'h008, 32'h20);
    bus_wr(0, 12'h000, 32'h1);
    check("R5 no warn before", warn, 0);
    cnt = 64'h11F; tick();
    check("R5 below deadline", warn, 0);
    cnt = 64'h120; tick();
    check("R5 warn rises", warn, 1);
    check("R6 rreq low at warn", rreq, 0);
    bus_rd(0, 12'h010, d); check("R5 reload", d, 32'h140);
    bus_rd(0, 12'h000, d); check("R2 status warn", d, 32'h3);
    cnt = 64'h13F; tick();
    check("R6 below second deadline", rreq, 0);
    cnt = 64'h140; tick();
    check("R6 rreq rises", rreq, 1);
    bus_rd(0, 12'h000, d); check("R2 status both", d, 32'h7);
    tick(); tick();
    check("R6 rreq holds", rreq, 1);

    // R4 deadline write keeps stages
    bus_wr(0, 12'h010, 32'h9000);
    check("R4 warn kept", warn, 1);
    check("R4 rreq kept", rreq, 1);
    bus_rd(0, 12'h010, d); check("R4 cmp written", d, 32'h9000);

    // R7 refresh clears
    cnt = 64'h200;
    bus_wr(1, 12'h000, 32'h0);
    check("R7 refresh clears warn", warn, 0);
    check("R7 refresh clears rreq", rreq, 0);
    bus_rd(0, 12'h010, d); check("R3 refresh deadline", d, 32'h220);

    // R10 reserved refresh write does not restart
    cnt = 64'h220; tick();
    check("R5 warn again", warn, 1);
    bus_wr(1, 12'h008, 32'h1);
    check("R10 reserved keeps warn", warn, 1);
    bus_rd(0, 12'h010, d); check("R10 reserved keeps cmp", d, 32'h240);

    // R7 control write clears
    cnt = 64'h230;
    bus_wr(0, 12'h000, 32'h1);
    check("R7 ctrl clears warn", warn, 0);
    bus_rd(0, 12'h010, d); check("R3 ctrl deadline", d, 32'h250);

    // R8 disabled: no timeout
    cnt = 64'h300;
    bus_wr(0, 12'h000, 32'h0);
    cnt = 64'h400;
    repeat (4) tick();
    check("R8 warn low", warn, 0);
    check("R8 rreq low", rreq, 0);

    // R7 offset write clears
    bus_wr(0, 12'h000, 32'h1);
    cnt = 64'h420; tick();
    check("R5 warn third", warn, 1);
    bus_wr(0, 12'h008, 32'h10);
    check("R7 offset clears warn", warn, 0);
    bus_rd(0, 12'h010, d); check("R3 offset deadline", d, 32'h430);
    bus_rd(0, 12'h008, d); check("R3 offset readback", d, 32'h10);

    finish_run();
  end
endmodule